// File: doc/BRIEF.md
# Reset and Limp-Home Supervisor

This block is the digital supervisor of a power-management controller. It watches five reset-cause strobes, produces an active-low reset pulse for each reset event, and keeps two sticky flags that track reset history. The first flag is the warning flag. The second is the limp-home control flag. While the control flag is set, an open-drain limp output is enabled and pulls its line low, so that backup hardware can take over. A general-purpose enable output follows a software control bit, but only in the two upper operating modes and never during a reset.

The length of each reset pulse depends on its cause. Undervoltage, power-up and overtemperature-exit resets follow a board strap: a short pulse when the strap is fitted and a long one when it is not. Every other cause always produces the short pulse. Software clears the flags through a small write port after it has handled a reset. A second reset that arrives while the warning flag is still set escalates to the limp output. Overtemperature mode holds the limp output active.

Top module: `rst_limp_supervisor`

## Requirements
- R1: Any reset event (at least one cause strobe high at a clock edge) sets `warn_o` from the next cycle.
- R2: A reset event that arrives while `warn_o` is already 1 sets `ctrl_o` from the next cycle. A reset event with `warn_o` at 0 leaves `ctrl_o` unchanged.
- R3: `limp_oe_o` is 1 exactly when `ctrl_o` is 1. It stays 1 after the reset pulse ends and until the control flag is cleared.
- R4: While `ot_mode_i` is 1, `ctrl_o` reads 1 from the next cycle onward. A software clear issued during that time has no effect.
- R5: A write with `wr_en_i`=1 clears `warn_o` when `wr_data_i[1]`=0 and clears `ctrl_o` when `wr_data_i[2]`=0. Writing 1 to either bit leaves that flag unchanged.
- R6: When a software clear and a hardware set of the same flag fall in the same cycle, the flag ends up set.
- R7: `en_o` is 1 only when the control bit (`wr_data_i[0]`, stored on a write) is 1, `mode_i` is 2'b10 or 2'b11, and no reset pulse is in progress. With `mode_i` at 2'b00 or 2'b01, `en_o` is 0.
- R8: A reset event clears the stored control bit, and this clear wins over a write in the same cycle. `en_o` is 0 while `rst_n_o` is 0.
- R9: For undervoltage, power-up or overtemperature-exit causes, `rst_n_o` is 0 for exactly SHORT_CYC cycles when `strap_short_i`=1 and for LONG_CYC cycles when it is 0. The pulse starts in the cycle after the strobe. If several causes arrive together, the long length is used when any of them selects it.
- R10: Watchdog and external causes alone always give a SHORT_CYC pulse, whatever the strap.
- R11: A reset event during a running pulse restarts the count at the new event's length.
- R12: After `rst_n` is released, `rst_n_o`=1, `warn_o`=0, `ctrl_o`=0, `limp_oe_o`=0 and `en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| ev_uv_i | input | 1 | Undervoltage reset strobe |
| ev_pwrup_i | input | 1 | Power-up-from-off reset strobe |
| ev_otexit_i | input | 1 | Overtemperature-exit reset strobe |
| ev_wdog_i | input | 1 | Watchdog reset strobe |
| ev_ext_i | input | 1 | External reset strobe |
| ot_mode_i | input | 1 | High while in overtemperature mode |
| strap_short_i | input | 1 | 1 = short-pulse strap fitted |
| mode_i | input | 2 | Current operating mode |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 3 | [0] enable control, [1] warning keep, [2] limp control keep |
| rst_n_o | output | 1 | Active-low reset pulse |
| limp_oe_o | output | 1 | Open-drain enable for the limp line (1 = pull low) |
| en_o | output | 1 | General-purpose enable output |
| warn_o | output | 1 | Warning flag |
| ctrl_o | output | 1 | Limp-home control flag |

## Verification
Every flag and the stored enable bit change one clock edge after the strobe or write that causes them. `en_o` also depends on `mode_i` combinationally, so it reacts in the same cycle. `rst_n_o` falls one edge after a cause strobe and rises again exactly SHORT_CYC or LONG_CYC edges later. The bench drives inputs on the falling edge and samples one full cycle later, so each sample falls after exactly one rising edge. It measures pulse length by counting the falling-edge samples at which `rst_n_o` is low, from the first sample after the strobe. It sweeps all 31 cause combinations against both strap settings, and all four modes against both enable-bit values.

// File: rtl/rls_pkg.sv
package rls_pkg;

    localparam int CAUSE_W = 5;

    typedef struct packed {
        logic uv;
        logic pwrup;
        logic ot_exit;
        logic wdog;
        logic ext;
    } rst_cause_t;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_AUX   = 2'b01,
        MODE_STBY  = 2'b10,
        MODE_RUN   = 2'b11
    } op_mode_t;

    localparam int WB_ENC  = 0;
    localparam int WB_WARN = 1;
    localparam int WB_CTRL = 2;
    localparam int WR_W    = 3;

    function automatic logic cause_follows_strap(input rst_cause_t c);
        return c.uv | c.pwrup | c.ot_exit;
    endfunction

endpackage

// File: rtl/rls_cause_decode.sv
module rls_cause_decode
    import rls_pkg::*;
(
    input  rst_cause_t cause_i,
    input  logic       strap_short_i,
    output logic       ev_o,
    output logic       long_o
);

    logic strap_dep;

    always_comb begin
        strap_dep = cause_follows_strap(cause_i);
        ev_o      = |cause_i;
        long_o    = strap_dep & ~strap_short_i;
    end

endmodule

// File: rtl/rls_pulse_timer.sv
module rls_pulse_timer #(
    parameter int unsigned SHORT_CYC = 50_000,
    parameter int unsigned LONG_CYC  = 1_000_000,
    parameter int unsigned CNT_W     = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    output logic active_o
);

    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = long_i ? LONG_C : SHORT_C;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = (st_q.cnt != '0);

    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !load_i) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    p_short_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !long_i) |=> (st_q.cnt == SHORT_C));

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> active_o);

endmodule

// File: rtl/rls_limp_flags.sv
module rls_limp_flags
    import rls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_i,
    input  logic            ot_mode_i,
    input  logic            wr_en_i,
    input  logic [WR_W-1:0] wr_data_i,
    output logic            warn_o,
    output logic            ctrl_o,
    output logic            limp_oe_o
);

    typedef struct packed {
        logic warn;
        logic ctrl;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !wr_data_i[WB_WARN]) st_d.warn = 1'b0;
        if (wr_en_i && !wr_data_i[WB_CTRL]) st_d.ctrl = 1'b0;
        if (ev_i) begin
            st_d.warn = 1'b1;
            if (st_q.warn) st_d.ctrl = 1'b1;
        end
        if (ot_mode_i) st_d.ctrl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn_o    = st_q.warn;
    assign ctrl_o    = st_q.ctrl;
    assign limp_oe_o = st_q.ctrl;

    p_warn_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> warn_o);

    p_escalate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && warn_o) |=> ctrl_o);

    p_ot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ot_mode_i |=> ctrl_o);

    p_ctrl_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o && !(wr_en_i && !wr_data_i[WB_CTRL])) |=> ctrl_o);

endmodule

// File: rtl/rls_enable_ctrl.sv
module rls_enable_ctrl
    import rls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_i,
    input  logic            pulse_active_i,
    input  logic [1:0]      mode_i,
    input  logic            wr_en_i,
    input  logic [WR_W-1:0] wr_data_i,
    output logic            en_o
);

    typedef struct packed {
        logic enc;
    } en_t;

    en_t      st_d, st_q;
    op_mode_t mode;
    logic     mode_ok;

    always_comb begin
        mode = op_mode_t'(mode_i);
        unique case (mode)
            MODE_STBY, MODE_RUN:  mode_ok = 1'b1;
            MODE_SLEEP, MODE_AUX: mode_ok = 1'b0;
            default:              mode_ok = 1'b0;
        endcase
        st_d = st_q;
        if (wr_en_i) st_d.enc = wr_data_i[WB_ENC];
        if (ev_i)    st_d.enc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.enc & mode_ok & ~pulse_active_i;

    p_en_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> mode_i[1]);

    p_en_off_after_ev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> !en_o);

endmodule

// File: rtl/rst_limp_supervisor.sv
module rst_limp_supervisor
    import rls_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 50_000,
    parameter int unsigned LONG_CYC  = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_uv_i,
    input  logic       ev_pwrup_i,
    input  logic       ev_otexit_i,
    input  logic       ev_wdog_i,
    input  logic       ev_ext_i,
    input  logic       ot_mode_i,
    input  logic       strap_short_i,
    input  logic [1:0] mode_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_data_i,
    output logic       rst_n_o,
    output logic       limp_oe_o,
    output logic       en_o,
    output logic       warn_o,
    output logic       ctrl_o
);

    localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);

    rst_cause_t cause;
    logic       ev;
    logic       ev_long;
    logic       pulse_active;

    always_comb begin
        cause.uv      = ev_uv_i;
        cause.pwrup   = ev_pwrup_i;
        cause.ot_exit = ev_otexit_i;
        cause.wdog    = ev_wdog_i;
        cause.ext     = ev_ext_i;
    end

    rls_cause_decode u_decode (
        .cause_i       (cause),
        .strap_short_i (strap_short_i),
        .ev_o          (ev),
        .long_o        (ev_long)
    );

    rls_pulse_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ev),
        .long_i   (ev_long),
        .active_o (pulse_active)
    );

    rls_limp_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .ot_mode_i (ot_mode_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .warn_o    (warn_o),
        .ctrl_o    (ctrl_o),
        .limp_oe_o (limp_oe_o)
    );

    rls_enable_ctrl u_enable (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_i           (ev),
        .pulse_active_i (pulse_active),
        .mode_i         (mode_i),
        .wr_en_i        (wr_en_i),
        .wr_data_i      (wr_data_i),
        .en_o           (en_o)
    );

    assign rst_n_o = ~pulse_active;

    p_ev_pulls_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !rst_n_o);

    p_limp_tracks_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        limp_oe_o == ctrl_o);

    p_en_off_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_n_o |-> !en_o);

endmodule

// File: tb/rst_limp_supervisor_bench.sv
module rst_limp_supervisor_bench;

    localparam int SHORT = 4;
    localparam int LONG  = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_uv_i = 0, ev_pwrup_i = 0, ev_otexit_i = 0, ev_wdog_i = 0, ev_ext_i = 0;
    logic       ot_mode_i = 0, strap_short_i = 0;
    logic [1:0] mode_i = 2'b00;
    logic       wr_en_i = 0;
    logic [2:0] wr_data_i = 3'b000;
    logic       rst_n_o, limp_oe_o, en_o, warn_o, ctrl_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rst_limp_supervisor #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) u_rst_limp_supervisor (
        .clk(clk), .rst_n(rst_n),
        .ev_uv_i(ev_uv_i), .ev_pwrup_i(ev_pwrup_i), .ev_otexit_i(ev_otexit_i),
        .ev_wdog_i(ev_wdog_i), .ev_ext_i(ev_ext_i),
        .ot_mode_i(ot_mode_i), .strap_short_i(strap_short_i), .mode_i(mode_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rst_n_o(rst_n_o), .limp_oe_o(limp_oe_o), .en_o(en_o),
        .warn_o(warn_o), .ctrl_o(ctrl_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_causes(input logic [4:0] c);
        {ev_uv_i, ev_pwrup_i, ev_otexit_i, ev_wdog_i, ev_ext_i} = c;
    endtask

    task automatic write(input logic [2:0] d);
        wr_en_i = 1; wr_data_i = d;
        step();
        wr_en_i = 0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!rst_n_o && n < 200) begin
            n++;
            step();
        end
    endtask

    task automatic fire(input logic [4:0] c, output int n);
        set_causes(c);
        step();
        set_causes(5'b0);
        measure(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        step(); step();
        rst_n = 1'b1;
        step();
        // R12 reset state
        check("R12 rst_n_o", rst_n_o, 1);
        check("R12 warn", warn_o, 0);
        check("R12 ctrl", ctrl_o, 0);
        check("R12 limp", limp_oe_o, 0);
        check("R12 en", en_o, 0);

        // R9 R10 R1: sweep of all cause combinations and both strap settings
        for (int s = 0; s < 2; s++) begin
            for (int c = 1; c < 32; c++) begin
                int exp_len;
                strap_short_i = s[0];
                write(3'b000);
                exp_len = (((c & 5'b11100) != 0) && s == 0) ? LONG : SHORT;
                set_causes(c[4:0]);
                step();
                set_causes(5'b0);
                check("R1 warn after event", warn_o, 1);
                check("R2 no escalation on first", ctrl_o, 0);
                measure(n);
                if ((c & 5'b11100) != 0) check("R9 pulse length", n, exp_len);
                else                     check("R10 pulse length", n, exp_len);
            end
        end

        // R2 R3 escalation
        strap_short_i = 1;
        write(3'b000);
        fire(5'b10000, n);
        check("R2 warn only", ctrl_o, 0);
        set_causes(5'b00010);
        step();
        set_causes(5'b0);
        check("R2 escalate ctrl", ctrl_o, 1);
        check("R3 limp active", limp_oe_o, 1);
        measure(n);
        check("R3 limp after pulse", limp_oe_o, 1);
        // R5: write 1 keeps, write 0 clears
        write(3'b110);
        check("R5 ctrl kept", ctrl_o, 1);
        check("R5 warn kept", warn_o, 1);
        write(3'b010);
        check("R5 ctrl cleared", ctrl_o, 0);
        check("R3 limp released", limp_oe_o, 0);
        check("R5 warn still set", warn_o, 1);
        write(3'b000);
        check("R5 warn cleared", warn_o, 0);
        write(3'b110);
        check("R5 write1 no set warn", warn_o, 0);
        check("R5 write1 no set ctrl", ctrl_o, 0);

        // R6 simultaneous clear and set
        set_causes(5'b00001); wr_en_i = 1; wr_data_i = 3'b000;
        step();
        set_causes(5'b0); wr_en_i = 0;
        check("R6 warn set wins", warn_o, 1);
        measure(n);
        set_causes(5'b00001); wr_en_i = 1; wr_data_i = 3'b000;
        step();
        set_causes(5'b0); wr_en_i = 0;
        check("R6 ctrl set wins", ctrl_o, 1);
        measure(n);
        write(3'b000);

        // R4 overtemperature hold
        ot_mode_i = 1;
        step();
        check("R4 ctrl held", ctrl_o, 1);
        check("R4 limp held", limp_oe_o, 1);
        write(3'b000);
        check("R4 clear ignored", ctrl_o, 1);
        ot_mode_i = 0;
        step();
        write(3'b000);
        check("R4 clear after exit", ctrl_o, 0);

        // R7 sweep of mode and enable bit
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 4; m++) begin
                mode_i = m[1:0];
                write({2'b11, e[0]});
                check("R7 en", en_o, (e == 1 && m >= 2) ? 1 : 0);
            end
        end

        // R8 reset clears enable bit, beats write
        mode_i = 2'b10;
        write(3'b111);
        check("R7 en on", en_o, 1);
        set_causes(5'b00010); wr_en_i = 1; wr_data_i = 3'b111;
        step();
        set_causes(5'b0); wr_en_i = 0;
        check("R8 en low on event", en_o, 0);
        measure(n);
        check("R8 enc cleared after pulse", en_o, 0);
        // R8: bit set during a pulse, output waits for pulse end
        set_causes(5'b00001);
        step();
        set_causes(5'b0);
        write(3'b111);
        check("R8 en low during pulse", en_o, 0);
        measure(n);
        check("R8 en high after pulse", en_o, 1);

        // R11 retrigger with shorter cause
        strap_short_i = 0;
        write(3'b110);
        set_causes(5'b10000);
        step();
        set_causes(5'b0);
        step(); step();
        set_causes(5'b00010);
        step();
        set_causes(5'b0);
        measure(n);
        check("R11 restart length", n, SHORT);
        // R11 retrigger extends with long cause
        set_causes(5'b00001);
        step();
        set_causes(5'b0);
        step();
        set_causes(5'b01000);
        step();
        set_causes(5'b0);
        measure(n);
        check("R11 restart long", n, LONG);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule